// File: doc/BRIEF.md
# Multichannel DAC Special-Command Controller

This block is the digital control core of a 40-channel, 12-bit DAC. It accepts command words that a front end has already deserialized. Each word carries a 2-bit register-select field, a 6-bit address and a 12-bit data field. If the select field is non-zero, the word writes one channel's data, gain or offset register. If the select field is zero, the address is decoded as a special command: no-op, load clear code, soft clear, soft power-down, soft power-up or soft reset.

The block holds the clear-code register, the per-channel registers and the software power-down flag. It drives an active-low busy output that is held low for timed operations. The lengths of those operations are set in clock cycles by a cycles-per-microsecond parameter. An active-low hardware clear input and an active-high hardware power-down input act alongside the software commands. Each channel's registers are read through an index port.

Top module: `dac_sfr_ctrl`

## Requirements
- R1: After reset, busy_n is 1, the software power-down flag is clear, clear_code is 0x000, and for every channel the data and offset read 0x000 and the gain reads 0xFFF.
- R2: A word is decoded as a special command only when cmd_sel is 2'b00. The special commands are selected by cmd_addr: 6'h00 no-op, 6'h01 load clear code, 6'h02 soft clear, 6'h08 soft power-down, 6'h09 soft power-up, 6'h0F soft reset. A word with a non-zero cmd_sel is always a channel write, whatever its address.
- R3: Load clear code stores cmd_data into clear_code and pulses busy_n low for one cycle.
- R4: Soft clear ignores cmd_data and copies clear_code into all 40 data registers in the cycle after acceptance. It holds busy_n low for 35*CYC_PER_US cycles. It acts even while powered down.
- R5: While clr_n is low, every data register is loaded with clear_code on each clock edge, including while powered down. In the same cycle, this has priority over a channel data write. Soft reset has priority over it.
- R6: Soft power-down raises pd_active on the next cycle and pulses busy_n for one cycle. While pd_active is 1, channel writes and load clear code are ignored, and all register contents are kept.
- R7: pd_active is 1 whenever hw_pd is 1, whenever the software flag is set, or while a power-up is in progress.
- R8: Soft power-up clears the software flag and holds busy_n low for 8*CYC_PER_US cycles. pd_active stays 1 throughout this time and falls (if hw_pd is 0) in the same cycle that busy_n rises.
- R9: Soft reset restores the state of R1, clears the software power-down flag and holds busy_n low for 135*CYC_PER_US cycles.
- R10: A no-op, or any special address not listed in R2, changes no state and pulses busy_n low for one cycle.
- R11: Any command presented while busy_n is 0 is ignored. While busy, the counter behind busy_n counts down by one on every cycle.
- R12: Channel writes use cmd_sel 2'b11 for data, 2'b10 for offset and 2'b01 for gain, to the channel given by cmd_addr. They apply only if cmd_addr < 40 and produce no busy pulse. Reading an index of 40 or above returns 0x000 on all three read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_sel | input | 2 | Register-select field |
| cmd_addr | input | 6 | Address / channel field |
| cmd_data | input | 12 | Data field |
| clr_n | input | 1 | Hardware clear, active low |
| hw_pd | input | 1 | Hardware power-down request |
| rd_chan | input | 6 | Channel index for readout |
| busy_n | output | 1 | Busy, active low |
| pd_active | output | 1 | Effective power-down state |
| clear_code | output | 12 | Current clear-code register |
| rd_data | output | 12 | Data register of rd_chan |
| rd_gain | output | 12 | Gain register of rd_chan |
| rd_offset | output | 12 | Offset register of rd_chan |

## Verification
The hardware clear input and an accepted channel data write can land on the same clock edge. The same is true of hardware clear and a load-clear-code command. The bench holds clr_n low for exactly the cycle that carries such a command, both in directed cases and at random in the constrained-random phase. It then judges every channel against a model in which the channel write is applied first and the bulk load of the old clear code overrides it, while a new clear code takes effect only for later clears. Soft reset arriving with clr_n low is judged the same way, with reset winning.

// File: rtl/dacsfr_pkg.sv
// Package: shared command types and address decode for the DAC command controller.
// Assumes a 6-bit address field; unlisted special addresses decode as no-op.
package dacsfr_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_WRCLR,
        OP_SCLR,
        OP_PDOWN,
        OP_PUP,
        OP_RESET
    } sfr_op_e;

    localparam logic [1:0] SEL_SFR    = 2'b00;
    localparam logic [1:0] SEL_GAIN   = 2'b01;
    localparam logic [1:0] SEL_OFFSET = 2'b10;
    localparam logic [1:0] SEL_DATA   = 2'b11;

    // Map a special-command address onto an operation.
    function automatic sfr_op_e decode_op(input logic [5:0] a);
        case (a)
            6'h01:   return OP_WRCLR;
            6'h02:   return OP_SCLR;
            6'h08:   return OP_PDOWN;
            6'h09:   return OP_PUP;
            6'h0F:   return OP_RESET;
            default: return OP_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sfr_cmd_decode.sv
// Command decode: splits an incoming word into a special command or a channel
// register write. Assumes busy_n and pd_active come from registered logic.
module sfr_cmd_decode
    import dacsfr_pkg::*;
#(
    parameter int NCH = 40,
    parameter int AW  = 6
) (
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_sel,
    input  logic [AW-1:0] cmd_addr,
    input  logic          busy_n,
    input  logic          pd_active,
    output logic          spec_go,
    output sfr_op_e       op,
    output logic          wr_data_en,
    output logic          wr_gain_en,
    output logic          wr_ofs_en
);

    logic accept;
    logic chan_ok;
    logic wr_ok;

    // Accept words only while idle; channel writes need a valid, powered channel.
    always_comb begin
        accept     = cmd_valid && busy_n;
        chan_ok    = cmd_addr < AW'(NCH);
        wr_ok      = accept && chan_ok && !pd_active;
        spec_go    = accept && (cmd_sel == SEL_SFR);
        op         = decode_op(cmd_addr);
        wr_data_en = wr_ok && (cmd_sel == SEL_DATA);
        wr_gain_en = wr_ok && (cmd_sel == SEL_GAIN);
        wr_ofs_en  = wr_ok && (cmd_sel == SEL_OFFSET);
    end

endmodule

// File: rtl/sfr_busy_timer.sv
// Busy timer: loads a cycle count for each accepted special command and holds
// busy_n low until it expires; tracks the power-up wake window.
// Assumes go is only raised while busy_n is 1.
module sfr_busy_timer
    import dacsfr_pkg::*;
#(
    parameter int CLR_CYC = 3500,
    parameter int RST_CYC = 13500,
    parameter int PU_CYC  = 800,
    localparam int MAXC   = (RST_CYC > CLR_CYC) ? ((RST_CYC > PU_CYC) ? RST_CYC : PU_CYC)
                                                : ((CLR_CYC > PU_CYC) ? CLR_CYC : PU_CYC),
    localparam int CW     = $clog2(MAXC + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  sfr_op_e op,
    output logic    busy_n,
    output logic    waking
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;
    logic          wake_q;

    // Select the busy length for the command being accepted.
    always_comb begin
        case (op)
            OP_SCLR:  load_val = CW'(CLR_CYC);
            OP_RESET: load_val = CW'(RST_CYC);
            OP_PUP:   load_val = CW'(PU_CYC);
            default:  load_val = CW'(1);
        endcase
    end

    // Countdown holding busy_n low.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (go)         cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - CW'(1);
    end

    // Wake window: set on power-up, cleared as the countdown ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wake_q <= 1'b0;
        else if (go && op == OP_PUP)   wake_q <= 1'b1;
        else if (cnt_q == CW'(1))      wake_q <= 1'b0;
    end

    assign busy_n = (cnt_q == '0);
    assign waking = wake_q;

    assert_busy_countdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    assert_wake_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> !busy_n);

endmodule

// File: rtl/sfr_chan_bank.sv
// Channel register bank: per-channel data, gain and offset registers with bulk
// clear, soft reset and indexed readout. Priority: reset, then bulk clear, then write.
module sfr_chan_bank #(
    parameter int NCH = 40,
    parameter int DW  = 12,
    parameter int AW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          bulk_clr,
    input  logic [DW-1:0] clr_val,
    input  logic          wr_data_en,
    input  logic          wr_gain_en,
    input  logic          wr_ofs_en,
    input  logic [AW-1:0] wr_ch,
    input  logic [DW-1:0] wr_val,
    input  logic [AW-1:0] rd_ch,
    output logic [DW-1:0] rd_dat,
    output logic [DW-1:0] rd_gain,
    output logic [DW-1:0] rd_ofs
);

    logic [DW-1:0] dat_q  [NCH];
    logic [DW-1:0] gain_q [NCH];
    logic [DW-1:0] ofs_q  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = (wr_ch == AW'(g));

        // Data register: reset, bulk clear, then write.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)       dat_q[g] <= '0;
            else if (bulk_clr)            dat_q[g] <= clr_val;
            else if (wr_data_en && hit)   dat_q[g] <= wr_val;
        end

        // Gain and offset registers: reset to full scale / zero, then write.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                gain_q[g] <= '1;
                ofs_q[g]  <= '0;
            end else begin
                if (wr_gain_en && hit) gain_q[g] <= wr_val;
                if (wr_ofs_en && hit)  ofs_q[g]  <= wr_val;
            end
        end

        assert_bulk_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bulk_clr && !soft_rst) |=> (dat_q[g] == $past(clr_val)));

        assert_reset_gain_R9: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> (gain_q[g] == '1 && ofs_q[g] == '0 && dat_q[g] == '0));
    end

    // Indexed readout; out-of-range index reads zero.
    always_comb begin
        rd_dat  = '0;
        rd_gain = '0;
        rd_ofs  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == AW'(i)) begin
                rd_dat  = dat_q[i];
                rd_gain = gain_q[i];
                rd_ofs  = ofs_q[i];
            end
        end
    end

endmodule

// File: rtl/dac_sfr_ctrl.sv
// Top: special-command controller for a multichannel DAC. Holds the clear code
// and the software power-down flag, combines hardware and software power-down,
// and ties decode, busy timer and channel bank together.
// Assumes clr_n and hw_pd are already synchronous to clk.
module dac_sfr_ctrl
    import dacsfr_pkg::*;
#(
    parameter int NCH        = 40,
    parameter int DW         = 12,
    parameter int AW         = 6,
    parameter int CYC_PER_US = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_sel,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          clr_n,
    input  logic          hw_pd,
    input  logic [AW-1:0] rd_chan,
    output logic          busy_n,
    output logic          pd_active,
    output logic [DW-1:0] clear_code,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_gain,
    output logic [DW-1:0] rd_offset
);

    localparam int CLR_CYC = 35 * CYC_PER_US;
    localparam int RST_CYC = 135 * CYC_PER_US;
    localparam int PU_CYC  = 8 * CYC_PER_US;

    logic          spec_go;
    sfr_op_e       op;
    logic          wr_data_en;
    logic          wr_gain_en;
    logic          wr_ofs_en;
    logic          waking;
    logic          soft_rst;
    logic          bulk_clr;
    logic          sw_pd_q;
    logic [DW-1:0] clr_code_q;

    sfr_cmd_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_sel    (cmd_sel),
        .cmd_addr   (cmd_addr),
        .busy_n     (busy_n),
        .pd_active  (pd_active),
        .spec_go    (spec_go),
        .op         (op),
        .wr_data_en (wr_data_en),
        .wr_gain_en (wr_gain_en),
        .wr_ofs_en  (wr_ofs_en)
    );

    sfr_busy_timer #(.CLR_CYC(CLR_CYC), .RST_CYC(RST_CYC), .PU_CYC(PU_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (spec_go),
        .op     (op),
        .busy_n (busy_n),
        .waking (waking)
    );

    // Derived strobes for the bank and the effective power-down state.
    always_comb begin
        soft_rst  = spec_go && (op == OP_RESET);
        bulk_clr  = !clr_n || (spec_go && (op == OP_SCLR));
        pd_active = hw_pd || sw_pd_q || waking;
    end

    // Clear-code register: reset, or load when powered.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            clr_code_q <= '0;
        else if (spec_go && op == OP_WRCLR && !pd_active)
            clr_code_q <= cmd_data;
    end

    // Software power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_pd_q <= 1'b0;
        else if (spec_go) begin
            case (op)
                OP_PDOWN:        sw_pd_q <= 1'b1;
                OP_PUP, OP_RESET: sw_pd_q <= 1'b0;
                default:         sw_pd_q <= sw_pd_q;
            endcase
        end
    end

    assign clear_code = clr_code_q;

    sfr_chan_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .bulk_clr   (bulk_clr),
        .clr_val    (clr_code_q),
        .wr_data_en (wr_data_en),
        .wr_gain_en (wr_gain_en),
        .wr_ofs_en  (wr_ofs_en),
        .wr_ch      (cmd_addr),
        .wr_val     (cmd_data),
        .rd_ch      (rd_chan),
        .rd_dat     (rd_data),
        .rd_gain    (rd_gain),
        .rd_ofs     (rd_offset)
    );

    assert_pd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && !soft_rst) |=> $stable(clr_code_q));

    assert_pdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_go && op == OP_PDOWN) |=> pd_active);

    assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy_n && clr_code_q == '0 && !sw_pd_q));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && cmd_valid) |=> $stable(clr_code_q));

endmodule

// File: tb/sim_dac_sfr_ctrl.sv
// Bench: directed corner cases plus seeded random commands against a bench model.
module sim_dac_sfr_ctrl;

    localparam int NCH = 40;
    localparam int CPU = 2;
    localparam int CLR_CYC = 35 * CPU;
    localparam int RST_CYC = 135 * CPU;
    localparam int PU_CYC  = 8 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_sel = '0;
    logic [5:0]  cmd_addr = '0;
    logic [11:0] cmd_data = '0;
    logic        clr_n = 1'b1;
    logic        hw_pd = 1'b0;
    logic [5:0]  rd_chan = '0;
    logic        busy_n;
    logic        pd_active;
    logic [11:0] clear_code;
    logic [11:0] rd_data;
    logic [11:0] rd_gain;
    logic [11:0] rd_offset;

    dac_sfr_ctrl #(.NCH(NCH), .DW(12), .AW(6), .CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .clr_n(clr_n), .hw_pd(hw_pd),
        .rd_chan(rd_chan), .busy_n(busy_n), .pd_active(pd_active),
        .clear_code(clear_code), .rd_data(rd_data), .rd_gain(rd_gain),
        .rd_offset(rd_offset)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_dat [NCH];
    logic [11:0] m_gain[NCH];
    logic [11:0] m_ofs [NCH];
    logic [11:0] m_clr;
    logic        m_swpd;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_dat[i] = '0; m_gain[i] = 12'hFFF; m_ofs[i] = '0;
        end
        m_clr = '0;
        m_swpd = 1'b0;
    endtask

    function automatic int exp_busy(input logic [1:0] s, input logic [5:0] a);
        if (s != 2'b00) return 0;
        case (a)
            6'h02:   return CLR_CYC;
            6'h09:   return PU_CYC;
            6'h0F:   return RST_CYC;
            default: return 1;
        endcase
    endfunction

    // Model of one accepted word (bench is idle when it is applied).
    task automatic model_apply(input logic [1:0] s, input logic [5:0] a,
                               input logic [11:0] d, input bit clr_low);
        logic        pd;
        logic [11:0] old;
        bit          rst;
        pd  = hw_pd | m_swpd;
        old = m_clr;
        rst = 1'b0;
        if (s != 2'b00) begin
            if (!pd && a < NCH) begin
                if (s == 2'b11) m_dat[a] = d;
                if (s == 2'b10) m_ofs[a] = d;
                if (s == 2'b01) m_gain[a] = d;
            end
        end else begin
            case (a)
                6'h01: if (!pd) m_clr = d;
                6'h02: for (int i = 0; i < NCH; i++) m_dat[i] = old;
                6'h08: m_swpd = 1'b1;
                6'h09: m_swpd = 1'b0;
                6'h0F: begin model_reset(); rst = 1'b1; end
                default: ;
            endcase
        end
        if (clr_low && !rst)
            for (int i = 0; i < NCH; i++) m_dat[i] = old;
    endtask

    task automatic issue(input logic [1:0] s, input logic [5:0] a,
                         input logic [11:0] d, input bit clr_low, input bit apply);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_sel = s; cmd_addr = a; cmd_data = d;
        clr_n = !clr_low;
        @(posedge clk);
        if (apply) model_apply(s, a, d, clr_low);
        @(negedge clk);
        cmd_valid = 1'b0; clr_n = 1'b1;
    endtask

    task automatic wait_busy(input int exp, input string req);
        int n = 0;
        while (!busy_n && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk(req, "busy_n low cycles", n, exp);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!busy_n && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_chan(input int ch, input string req);
        rd_chan = 6'(ch);
        #1;
        chk(req, $sformatf("data ch%0d", ch), rd_data, m_dat[ch]);
        chk(req, $sformatf("gain ch%0d", ch), rd_gain, m_gain[ch]);
        chk(req, $sformatf("offset ch%0d", ch), rd_offset, m_ofs[ch]);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < NCH; i++) check_chan(i, req);
    endtask

    task automatic check_state(input string req);
        chk(req, "clear_code", clear_code, m_clr);
        chk(req, "pd_active", pd_active, hw_pd | m_swpd);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1234_5EED);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "busy_n", busy_n, 1'b1);
        check_state("R1");
        sweep("R1");

        // R12: channel writes, including edge channels and out-of-range
        issue(2'b11, 6'd0, 12'h123, 0, 1);  wait_busy(0, "R12");
        issue(2'b11, 6'd39, 12'hABC, 0, 1); wait_busy(0, "R12");
        issue(2'b01, 6'd5, 12'h456, 0, 1);  wait_busy(0, "R12");
        issue(2'b10, 6'd7, 12'h789, 0, 1);  wait_busy(0, "R12");
        issue(2'b11, 6'd45, 12'hEEE, 0, 1); wait_busy(0, "R12");
        sweep("R12");
        rd_chan = 6'd45; #1;
        chk("R12", "oob read data", rd_data, 12'h000);
        chk("R12", "oob read gain", rd_gain, 12'h000);

        // R3: load clear code
        issue(2'b00, 6'h01, 12'hA5C, 0, 1);
        wait_busy(1, "R3");
        check_state("R3");

        // R2: non-zero select with special address is a channel write
        issue(2'b11, 6'h02, 12'h321, 0, 1);
        wait_busy(0, "R2");
        check_chan(2, "R2");
        check_chan(3, "R2");

        // R4: soft clear ignores data field
        issue(2'b00, 6'h02, 12'h777, 0, 1);
        wait_busy(CLR_CYC, "R4");
        check_state("R4");
        sweep("R4");

        // R11: commands during busy are ignored
        issue(2'b00, 6'h02, 12'h000, 0, 1);
        issue(2'b00, 6'h01, 12'h111, 0, 0);
        issue(2'b00, 6'h08, 12'h000, 0, 0);
        issue(2'b11, 6'd4, 12'h999, 0, 0);
        wait_idle();
        check_state("R11");
        check_chan(4, "R11");

        // R6: soft power-down blocks writes, keeps contents
        issue(2'b00, 6'h08, 12'h000, 0, 1);
        wait_busy(1, "R6");
        chk("R6", "pd_active after power-down", pd_active, 1'b1);
        issue(2'b11, 6'd3, 12'hFFF, 0, 1);
        issue(2'b00, 6'h01, 12'h222, 0, 1);
        wait_idle();
        check_state("R6");
        check_chan(3, "R6");

        // R5: hardware clear while powered down
        issue(2'b01, 6'd20, 12'h0F0, 1, 1);
        wait_idle();
        sweep("R5");

        // R8: power-up wake window
        issue(2'b00, 6'h09, 12'h000, 0, 1);
        chk("R8", "pd_active during wake", pd_active, 1'b1);
        wait_busy(PU_CYC, "R8");
        chk("R8", "pd_active after wake", pd_active, 1'b0);

        // R7: hardware power-down alone
        @(negedge clk); hw_pd = 1'b1; #1;
        chk("R7", "pd_active from hw_pd", pd_active, 1'b1);
        issue(2'b11, 6'd8, 12'h5A5, 0, 1);
        check_chan(8, "R7");
        @(negedge clk); hw_pd = 1'b0; #1;
        chk("R7", "pd_active released", pd_active, 1'b0);

        // R5: hardware clear concurrent with channel write and clear-code load
        issue(2'b00, 6'h01, 12'h3C3, 0, 1); wait_idle();
        issue(2'b11, 6'd10, 12'h0AA, 1, 1); wait_idle();
        check_chan(10, "R5");
        issue(2'b00, 6'h01, 12'h5E5, 1, 1); wait_idle();
        sweep("R5");
        check_state("R5");

        // R10: no-op and unlisted address
        issue(2'b00, 6'h00, 12'hFFF, 0, 1);
        wait_busy(1, "R10");
        issue(2'b00, 6'h3F, 12'hFFF, 0, 1);
        wait_busy(1, "R10");
        check_state("R10");
        sweep("R10");

        // R9: soft reset from powered-down state with clear asserted
        issue(2'b00, 6'h08, 12'h000, 0, 1); wait_idle();
        issue(2'b00, 6'h0F, 12'h000, 1, 1);
        wait_busy(RST_CYC, "R9");
        check_state("R9");
        sweep("R9");

        // Random phase
        for (int k = 0; k < 250; k++) begin
            logic [1:0]  s;
            logic [5:0]  a;
            logic [11:0] d;
            bit          cl;
            int          r;
            string       tag;
            r  = $urandom_range(0, 9);
            d  = 12'($urandom());
            cl = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) begin
                @(negedge clk); hw_pd = ~hw_pd;
            end
            case (r)
                0, 1, 2, 3: begin s = 2'($urandom_range(1, 3)); a = 6'($urandom_range(0, 47)); tag = "R12"; end
                4: begin s = 2'b00; a = 6'h01; tag = "R3"; end
                5: begin s = 2'b00; a = 6'h02; tag = "R4"; end
                6: begin s = 2'b00; a = 6'h08; tag = "R6"; end
                7: begin s = 2'b00; a = 6'h09; tag = "R8"; end
                8: begin s = 2'b00; a = ($urandom_range(0, 1) == 0) ? 6'h00 : 6'h30; tag = "R10"; end
                default: begin
                    s = 2'b00;
                    if ($urandom_range(0, 3) == 0) begin a = 6'h0F; tag = "R9"; end
                    else begin a = 6'h04; tag = "R10"; end
                end
            endcase
            issue(s, a, d, cl, 1);
            wait_busy(exp_busy(s, a), tag);
            check_state(cl ? "R5" : tag);
            check_chan($urandom_range(0, NCH - 1), cl ? "R5" : tag);
            if (k % 50 == 49) sweep("R7");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule